// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block controls a 16-pin general-purpose I/O port through a small memory-mapped register interface. An output data latch drives the pins. Software can load the latch directly. It can also change single bits without a read-modify-write sequence, using a write-only clear register and a write-only toggle register.

Each pin input passes through a two-flop synchronizer. It is then watched for a transition in the direction that the pin's polarity bit selects. When an edge arrives on a pin whose interrupt is enabled, a sticky status flag for that pin is set. Software clears the flag by writing a one to it. A single interrupt line is high while any enabled pin holds a raised flag.

The bus writes on a one-cycle strobe. Read data is a combinational view of the register at the presented address.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the data, polarity, enable and status registers all read 0x0000, pinOut is 0x0000 and irqOut is 0.
- R2: Offset 0x14 is the output data register. A write loads it, a read returns it, and pinOut equals its value from the cycle after the write. pinOut changes only through writes to 0x14, 0x1C or 0x20.
- R3: Offset 0x1C is the clear register. Writing 1 in bit n makes pinOut[n] 0. Writing 0 in a bit leaves that bit unchanged. A read of 0x1C returns 0x0000.
- R4: Offset 0x20 is the toggle register. Writing 1 in bit n inverts pinOut[n]. Writing 0 in a bit leaves that bit unchanged. A read of 0x20 returns 0x0000.
- R5: Offset 0x24 is the polarity register and can be read and written. Bit n = 0 selects a high-to-low transition of pinIn[n] as the trigger. Bit n = 1 selects a low-to-high transition. A transition in the other direction does not trigger.
- R6: Offset 0x28 is the interrupt enable register and can be read and written. An edge on a pin whose enable bit is 0 does not set that pin's status bit.
- R7: Offset 0x2C is the status register. A selected edge on an enabled pin sets its bit, and the bit stays set. The bit reads back as 1 no later than the third rising clock edge after pinIn changes.
- R8: Writing 1 to bit n of 0x2C clears status bit n. Writing 0 to a bit leaves that bit unchanged.
- R9: When a status set and a clear write for the same bit are applied at the same clock edge, the bit ends up set.
- R10: irqOut is 1 exactly when some status bit is 1 and the matching enable bit is also 1. Clearing an enable bit drops its contribution to irqOut without clearing the status bit.
- R11: Addresses other than 0x14, 0x1C, 0x20, 0x24, 0x28 and 0x2C read 0x0000. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWr | input | 1 | One-cycle write strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| pinIn | input | 16 | Asynchronous pin inputs |
| pinOut | output | 16 | Output data latch driving the pins |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The latch is driven with a mixed data word, then with clear and toggle masks. Each mask mixes ones and zeros, so the touched bits are told apart from the bits that must hold. Pin inputs make rising and falling transitions on pins set for each polarity, so a matched edge is told apart from an opposite-direction edge. The same transitions are repeated on pins whose enable bit is off, which separates the enable gating from the edge selection. A clear write is timed to land on the same clock edge as a new edge, which shows that the set takes priority. Removing and restoring an enable bit while its flag is held shows that irqOut is gated while the status flag is kept.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam logic [7:0] OFF_DATA = 8'h14;
  localparam logic [7:0] OFF_CLR  = 8'h1C;
  localparam logic [7:0] OFF_TGL  = 8'h20;
  localparam logic [7:0] OFF_POL  = 8'h24;
  localparam logic [7:0] OFF_EN   = 8'h28;
  localparam logic [7:0] OFF_STAT = 8'h2C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DATA,
    RD_POL,
    RD_EN,
    RD_STAT
  } rdSel_t;

  typedef struct packed {
    logic   wrData;
    logic   wrClr;
    logic   wrTgl;
    logic   wrPol;
    logic   wrEn;
    logic   wrStat;
    rdSel_t rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stageQ[s] <= '0;
        end else if (s == 0) begin
          stageQ[s] <= asyncIn;
        end else begin
          stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output ctrlStrobes_t      strobes
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_NONE;
    strobes.wrData = busWr && hit(busAddr, OFF_DATA);
    strobes.wrClr  = busWr && hit(busAddr, OFF_CLR);
    strobes.wrTgl  = busWr && hit(busAddr, OFF_TGL);
    strobes.wrPol  = busWr && hit(busAddr, OFF_POL);
    strobes.wrEn   = busWr && hit(busAddr, OFF_EN);
    strobes.wrStat = busWr && hit(busAddr, OFF_STAT);
    if (hit(busAddr, OFF_DATA))      strobes.rdSel = RD_DATA;
    else if (hit(busAddr, OFF_POL))  strobes.rdSel = RD_POL;
    else if (hit(busAddr, OFF_EN))   strobes.rdSel = RD_EN;
    else if (hit(busAddr, OFF_STAT)) strobes.rdSel = RD_STAT;
  end

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOut,
  output logic [W-1:0] statusVec,
  output logic [W-1:0] enableVec,
  output logic [W-1:0] rdata
);

  logic [W-1:0] dataQ, polQ, enQ, statQ;
  logic [W-1:0] pinSync, prevQ, edgeHit, statClr;

  gpio_edge_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      polQ  <= '0;
      enQ   <= '0;
      prevQ <= '0;
    end else begin
      prevQ <= pinSync;
      if (strobes.wrData)     dataQ <= wdata;
      else if (strobes.wrClr) dataQ <= dataQ & ~wdata;
      else if (strobes.wrTgl) dataQ <= dataQ ^ wdata;
      if (strobes.wrPol) polQ <= wdata;
      if (strobes.wrEn)  enQ  <= wdata;
    end
  end

  assign statClr = strobes.wrStat ? wdata : '0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      always_comb begin
        if (polQ[i]) edgeHit[i] = pinSync[i] & ~prevQ[i];
        else         edgeHit[i] = ~pinSync[i] & prevQ[i];
      end

      always_ff @(posedge clk) begin
        if (!rstN)                       statQ[i] <= 1'b0;
        else if (edgeHit[i] && enQ[i])   statQ[i] <= 1'b1;
        else if (statClr[i])             statQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    unique case (strobes.rdSel)
      RD_DATA: rdata = dataQ;
      RD_POL:  rdata = polQ;
      RD_EN:   rdata = enQ;
      RD_STAT: rdata = statQ;
      default: rdata = '0;
    endcase
  end

  assign pinOut    = dataQ;
  assign statusVec = statQ;
  assign enableVec = enQ;

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int W           = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  input  logic [W-1:0]      pinIn,
  output logic [W-1:0]      pinOut,
  output logic              irqOut
);

  ctrlStrobes_t strobes;
  logic [W-1:0] statusVec, enableVec;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobes (strobes)
  );

  gpio_edge_dp #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .statusVec (statusVec),
    .enableVec (enableVec),
    .rdata     (busRdata)
  );

  assign irqOut = |(statusVec & enableVec);

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int W      = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [W-1:0]      busWdata,
  input logic [W-1:0]      pinOut,
  input logic [W-1:0]      statQ,
  input logic [W-1:0]      ienQ
);

  logic         clrWr, tglWr, dataWr, latchTouch;
  logic [W-1:0] w1cMask;

  assign dataWr     = busWr && busAddr == ADDR_W'(8'h14);
  assign clrWr      = busWr && busAddr == ADDR_W'(8'h1C);
  assign tglWr      = busWr && busAddr == ADDR_W'(8'h20);
  assign latchTouch = dataWr || clrWr || tglWr;
  assign w1cMask    = (busWr && busAddr == ADDR_W'(8'h2C)) ? busWdata : '0;

  // R2: latch holds without a data, clear or toggle write
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !latchTouch |=> $stable(pinOut));

  // R3: clear write forces masked bits low
  p_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> (pinOut & $past(busWdata)) == '0);

  // R4: toggle write inverts masked bits only
  p_tgl_r4: assert property (@(posedge clk) disable iff (!rstN)
    tglWr |=> pinOut == ($past(pinOut) ^ $past(busWdata)));

  // R6: a status bit may only rise where the enable was on
  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(ienQ)) == '0));

  // R8: a status bit only falls through a write-one-to-clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(statQ) & ~$past(w1cMask) & ~statQ) == '0));

endmodule

bind gpio_edge_port gpio_edge_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .pinOut   (pinOut),
  .statQ    (statusVec),
  .ienQ     (enableVec)
);

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 pinOut, 2 irqOut
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];

  always #10 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .irqOut(irqOut)
  );

  // monitor: pop expectations and compare away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = expQ.pop_front();
      case (it.kind)
        0:       act = busRdata;
        1:       act = pinOut;
        default: act = {15'd0, irqOut};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic expRead(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    busAddr = a;
    expQ.push_back('{0, e, tag});
  endtask

  task automatic expPin(input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{1, e, tag});
  endtask

  task automatic expIrq(input logic e, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{2, {15'd0, e}, tag});
  endtask

  task automatic drivePins(input logic [15:0] v);
    @(posedge clk); #1;
    pinIn = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expRead(8'h14, 16'h0000, "R1 data");
    expRead(8'h24, 16'h0000, "R1 polarity");
    expRead(8'h28, 16'h0000, "R1 enable");
    expRead(8'h2C, 16'h0000, "R1 status");
    expPin(16'h0000, "R1 pinOut");
    expIrq(1'b0, "R1 irqOut");

    // R2 data register
    wr(8'h14, 16'hA5C3);
    expRead(8'h14, 16'hA5C3, "R2 readback");
    expPin(16'hA5C3, "R2 pinOut");

    // R3 clear
    wr(8'h1C, 16'h00FF);
    expPin(16'hA500, "R3 clear mask");
    expRead(8'h1C, 16'h0000, "R3 read zero");

    // R4 toggle
    wr(8'h20, 16'hF00F);
    expPin(16'h550F, "R4 toggle mask");
    expRead(8'h20, 16'h0000, "R4 read zero");

    // R11 unmapped
    wr(8'h18, 16'hFFFF);
    expRead(8'h18, 16'h0000, "R11 unmapped read");
    expRead(8'h14, 16'h550F, "R11 unmapped write ignored");
    expPin(16'h550F, "R11 pinOut unchanged");

    // R5 / R6 configuration
    wr(8'h24, 16'h00F0);
    expRead(8'h24, 16'h00F0, "R5 polarity readback");
    wr(8'h28, 16'h00FF);
    expRead(8'h28, 16'h00FF, "R6 enable readback");

    // R7/R5: bit0 rises (falling selected), bit4 rises (rising selected)
    drivePins(16'h0011);
    expRead(8'h2C, 16'h0010, "R7 rising edge sets, R5 opposite ignored");
    expIrq(1'b1, "R10 irq raised");
    // bit4 falls (rising selected): no set
    drivePins(16'h0001);
    expRead(8'h2C, 16'h0010, "R5 falling ignored on rising pin");
    // bit0 falls (falling selected): set
    drivePins(16'h0000);
    expRead(8'h2C, 16'h0011, "R7 falling edge sets");

    // R6 disabled pin 8 toggles both ways
    drivePins(16'h0100);
    drivePins(16'h0000);
    expRead(8'h2C, 16'h0011, "R6 disabled pin ignored");

    // R8 write-one-to-clear
    wr(8'h2C, 16'h0001);
    expRead(8'h2C, 16'h0010, "R8 clear bit0");
    wr(8'h2C, 16'h0000);
    expRead(8'h2C, 16'h0010, "R8 zero write keeps");

    // R10 enable gating
    wr(8'h28, 16'h00EF);
    expIrq(1'b0, "R10 irq gated by enable");
    expRead(8'h2C, 16'h0010, "R10 status kept while gated");
    wr(8'h28, 16'h00FF);
    expIrq(1'b1, "R10 irq restored");
    wr(8'h2C, 16'h0010);
    expRead(8'h2C, 16'h0000, "R8 clear bit4");
    expIrq(1'b0, "R10 irq low with no status");

    // R9 set beats clear at the same edge: pin5 rises, set lands third edge
    @(posedge clk); #1;
    pinIn = 16'h0020;
    @(posedge clk);
    @(posedge clk); #1;
    busAddr = 8'h2C; busWdata = 16'h0020; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
    expRead(8'h2C, 16'h0020, "R9 set wins over clear");
    wr(8'h2C, 16'h0020);
    expRead(8'h2C, 16'h0000, "R9 later clear works");

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule